// File: doc/BRIEF.md
# Receive FIFO Status and RTS Controller

This block sits between the serial receiver of one UART channel and the host side. It holds up to sixteen received characters. Each character carries three error flags with it: a framing error, a parity error and a received break. The block shows the oldest character, which is the next one the host reads. It also shows a status byte. In character mode the status byte holds the flags of that oldest character. In block mode it holds a sticky OR of the flags of every character that has become the oldest since the host last issued an error-clear command.

The block also drives an active-low request-to-send output. The host can assert or negate it with direct commands. When the automatic function is enabled, the output is negated if the receiver reports a valid start bit while the FIFO is three quarters full or more. It is asserted again once the fill level falls below that mark. A push into a full FIFO is dropped and sets a sticky overrun bit. A pop from an empty FIFO changes nothing. DEPTH must be a power of two.

Top module: `rx_fifo_status_rts`

## Requirements
- R1: Characters leave in the order they arrived. `rxData` shows the oldest held character and `fillCount` shows the number held, from 0 to 16. A push and a pop in the same cycle are both performed.
- R2: With `blockMode` low, status bits 7, 6 and 5 hold the break, framing and parity flags of the oldest held character. These bits are 0 when the FIFO is empty.
- R3: With `blockMode` high, status bits 7, 6 and 5 are the OR of the flags of every character that has become the oldest entry since the last `errReset`. A character becomes the oldest entry when it is pushed into an empty FIFO, or when a pop exposes it.
- R4: `errReset` clears the accumulation and the overrun bit. A character that becomes the oldest entry in the same cycle, or an overrun in that same cycle, still counts after the clear.
- R5: A push into a full FIFO without a pop in the same cycle is discarded and sets status bit 4 (overrun). The overrun bit stays set until `errReset`. Status bit 1 shows full and bit 0 shows not-empty. Bits 3 and 2 are always 0.
- R6: A pop from an empty FIFO leaves the count unchanged. `rxData` then shows the last character that was popped, or 0 if no character has been popped since reset.
- R7: With `autoRtsEn` high and no host command, `startBit` while 12 or more characters are held drives `rtsN` high in the next cycle.
- R8: After an automatic negation, `rtsN` returns low in the cycle after the fill level is below 12. Clearing `autoRtsEn` cancels the pending return.
- R9: `rtsOffCmd` drives `rtsN` high and `rtsOnCmd` drives it low. The off command wins if both are given. A host command overrides the automatic function in the same cycle and cancels a pending return.
- R10: After reset, `rtsN` is high, the count is 0, the status byte is 0 and `rxData` is 0.
- R11: `startBit` with fewer than 12 characters held, or with `autoRtsEn` low, leaves `rtsN` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Receiver delivers a character this cycle |
| pushData | input | 8 | Received character |
| pushFrameErr | input | 1 | Framing error flag of the character |
| pushParityErr | input | 1 | Parity error flag of the character |
| pushBreak | input | 1 | Received break flag of the character |
| startBit | input | 1 | Receiver detected a valid start bit |
| popReq | input | 1 | Host reads the oldest character |
| errReset | input | 1 | Host error-clear command |
| blockMode | input | 1 | 0 selects character status, 1 selects block accumulation |
| autoRtsEn | input | 1 | Enables automatic RTS control |
| rtsOnCmd | input | 1 | Host command to assert RTS |
| rtsOffCmd | input | 1 | Host command to negate RTS |
| rxData | output | 8 | Oldest character, or the last popped one when empty |
| statusByte | output | 8 | {break, framing, parity, overrun, 0, 0, full, notEmpty} |
| fillCount | output | 5 | Number of characters held |
| rtsN | output | 1 | Active-low request to send |

## Verification
The assertions check, on every cycle, the properties that a single step can show:
- the count stays in range;
- full-FIFO writes and empty-FIFO reads leave the pointers alone;
- an overrun always sets its bit;
- the block accumulator never loses a bit except on an error-clear;
- the RTS output follows a host command or an automatic negation one cycle later.

Some behaviour spans several cycles and only the bench scenarios can show it:
- the pairing of each flag set with the right character through pointer wrap;
- the exact set of characters counted into a block accumulation;
- the same-cycle clear-and-arrive case;
- the delayed return of RTS once the FIFO drains below the mark.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;
  // Number of error flags carried with each character: {break, framing, parity}
  localparam int FLAG_W = 3;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic wrEn;        // store the pushed character
    logic rdEn;        // retire the oldest character
    logic arrivePush;  // pushed character becomes the oldest entry
    logic arriveNext;  // entry behind the oldest becomes the oldest
    logic overrunSet;  // push refused because the FIFO is full
    logic clearErr;    // clear accumulated errors and overrun
  } rxfsStrobes_t;
endpackage

// File: rtl/rxfs_ctrl.sv
module rxfs_ctrl
  import rxfs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             popReq,
  input  logic             errReset,
  input  logic             startBit,
  input  logic             autoRtsEn,
  input  logic             rtsOnCmd,
  input  logic             rtsOffCmd,
  output rxfsStrobes_t     strb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] fillCount,
  output logic             empty,
  output logic             full,
  output logic             rtsN
);
  localparam int RTS_LEVEL = (DEPTH * 3) / 4;

  logic popOk;
  logic pushOk;
  logic autoHold;
  logic aboveMark;

  assign empty     = (fillCount == '0);
  assign full      = (fillCount == CNT_W'(DEPTH));
  assign aboveMark = (fillCount >= CNT_W'(RTS_LEVEL));

  // A pop on an empty FIFO is ignored; a full FIFO accepts a push only alongside a pop
  assign popOk  = popReq && !empty;
  assign pushOk = pushValid && (!full || popOk);

  always_comb begin
    strb            = '0;
    strb.wrEn       = pushOk;
    strb.rdEn       = popOk;
    strb.arriveNext = popOk && (fillCount >= CNT_W'(2));
    strb.arrivePush = pushOk && (empty || (popOk && fillCount == CNT_W'(1)));
    strb.overrunSet = pushValid && !pushOk;
    strb.clearErr   = errReset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + 1'b1;
      if (popOk)  rdPtr <= rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  // RTS: host commands first, then automatic negate and return
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtsN     <= 1'b1;
      autoHold <= 1'b0;
    end else if (rtsOffCmd) begin
      rtsN     <= 1'b1;
      autoHold <= 1'b0;
    end else if (rtsOnCmd) begin
      rtsN     <= 1'b0;
      autoHold <= 1'b0;
    end else if (!autoRtsEn) begin
      autoHold <= 1'b0;
    end else if (startBit && aboveMark) begin
      rtsN     <= 1'b1;
      autoHold <= 1'b1;
    end else if (autoHold && !aboveMark) begin
      rtsN     <= 1'b0;
      autoHold <= 1'b0;
    end
  end

  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  assert_full_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    full && pushValid && !popReq |=> full && $stable(wrPtr));

  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    empty && popReq && !pushValid |=> empty && $stable(rdPtr));

  assert_auto_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    autoRtsEn && startBit && aboveMark && !rtsOnCmd && !rtsOffCmd |=> rtsN);

  assert_host_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    rtsOffCmd |=> rtsN);

  assert_host_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    rtsOnCmd && !rtsOffCmd |=> !rtsN);
endmodule

// File: rtl/rxfs_datapath.sv
module rxfs_datapath
  import rxfs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxfsStrobes_t      strb,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic              empty,
  input  logic              full,
  input  logic              blockMode,
  input  logic [DATA_W-1:0] pushData,
  input  logic [FLAG_W-1:0] pushFlags,
  output logic [DATA_W-1:0] rxData,
  output logic [7:0]        statusByte
);
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [FLAG_W-1:0] flagMem [DEPTH];
  logic [DATA_W-1:0] lastPopped;
  logic [FLAG_W-1:0] blockAcc;
  logic [FLAG_W-1:0] arriveFlags;
  logic [FLAG_W-1:0] flagsOut;
  logic [PTR_W-1:0]  nextRd;
  logic              overrunFlag;

  assign nextRd = rdPtr + 1'b1;

  // Storage: the data and flag arrays are written together on every accepted push
  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      dataMem[wrPtr] <= pushData;
      flagMem[wrPtr] <= pushFlags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          lastPopped <= '0;
    else if (strb.rdEn) lastPopped <= dataMem[rdPtr];
  end

  // Flags of the character that becomes the oldest entry this cycle
  always_comb begin
    if (strb.arriveNext)      arriveFlags = flagMem[nextRd];
    else if (strb.arrivePush) arriveFlags = pushFlags;
    else                      arriveFlags = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockAcc    <= '0;
      overrunFlag <= 1'b0;
    end else begin
      blockAcc    <= (strb.clearErr ? '0 : blockAcc) | arriveFlags;
      overrunFlag <= (strb.clearErr ? 1'b0 : overrunFlag) | strb.overrunSet;
    end
  end

  always_comb begin
    if (blockMode)  flagsOut = blockAcc;
    else if (empty) flagsOut = '0;
    else            flagsOut = flagMem[rdPtr];
  end

  assign rxData     = empty ? lastPopped : dataMem[rdPtr];
  assign statusByte = {flagsOut, overrunFlag, 2'b00, full, !empty};

  assert_acc_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearErr |=> ((blockAcc & $past(blockAcc)) == $past(blockAcc)));

  assert_overrun_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.overrunSet |=> statusByte[4]);

  assert_overrun_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    overrunFlag && !strb.clearErr |=> overrunFlag);
endmodule

// File: rtl/rx_fifo_status_rts.sv
module rx_fifo_status_rts
  import rxfs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pushFrameErr,
  input  logic              pushParityErr,
  input  logic              pushBreak,
  input  logic              startBit,
  input  logic              popReq,
  input  logic              errReset,
  input  logic              blockMode,
  input  logic              autoRtsEn,
  input  logic              rtsOnCmd,
  input  logic              rtsOffCmd,
  output logic [DATA_W-1:0] rxData,
  output logic [7:0]        statusByte,
  output logic [CNT_W-1:0]  fillCount,
  output logic              rtsN
);
  rxfsStrobes_t     strb;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             empty;
  logic             full;

  rxfs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReq(popReq),
    .errReset(errReset), .startBit(startBit), .autoRtsEn(autoRtsEn),
    .rtsOnCmd(rtsOnCmd), .rtsOffCmd(rtsOffCmd), .strb(strb),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .fillCount(fillCount),
    .empty(empty), .full(full), .rtsN(rtsN)
  );

  rxfs_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .empty(empty), .full(full), .blockMode(blockMode), .pushData(pushData),
    .pushFlags({pushBreak, pushFrameErr, pushParityErr}),
    .rxData(rxData), .statusByte(statusByte)
  );
endmodule

// File: tb/rx_fifo_status_rts_test.sv
module rx_fifo_status_rts_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 0, pushFrameErr = 0, pushParityErr = 0, pushBreak = 0;
  logic [7:0] pushData = '0;
  logic startBit = 0, popReq = 0, errReset = 0, blockMode = 0, autoRtsEn = 0;
  logic rtsOnCmd = 0, rtsOffCmd = 0;
  logic [7:0] rxData, statusByte;
  logic [4:0] fillCount;
  logic rtsN;

  int total = 0;
  int bad = 0;

  // Reference model state
  logic [10:0] mq[$];   // {brk, fe, pe, data}
  logic [2:0]  mAcc = '0;
  logic        mOv = 0;
  logic [7:0]  mLast = '0;
  logic        mRts = 1;
  logic        mHold = 0;

  always #4 clk = ~clk;

  rx_fifo_status_rts uut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .pushFrameErr(pushFrameErr), .pushParityErr(pushParityErr),
    .pushBreak(pushBreak), .startBit(startBit), .popReq(popReq),
    .errReset(errReset), .blockMode(blockMode), .autoRtsEn(autoRtsEn),
    .rtsOnCmd(rtsOnCmd), .rtsOffCmd(rtsOffCmd), .rxData(rxData),
    .statusByte(statusByte), .fillCount(fillCount), .rtsN(rtsN)
  );

  function automatic logic [7:0] expStatus();
    logic [2:0] f;
    int n = mq.size();
    if (blockMode) f = mAcc;
    else if (n > 0) f = mq[0][10:8];
    else f = '0;
    return {f, mOv, 2'b00, n == 16, n > 0};
  endfunction

  function automatic logic [7:0] expData();
    return (mq.size() > 0) ? mq[0][7:0] : mLast;
  endfunction

  // Advance the model by one clock using the inputs currently applied
  function automatic void modelStep();
    int n = mq.size();
    logic popOk = popReq && n > 0;
    logic pushOk = pushValid && (n < 16 || popOk);
    logic [2:0] pf = {pushBreak, pushFrameErr, pushParityErr};
    logic [2:0] arr = '0;
    if (popOk && n >= 2) arr = mq[1][10:8];
    else if (pushOk && (n == 0 || (popOk && n == 1))) arr = pf;
    mAcc = (errReset ? 3'b000 : mAcc) | arr;
    mOv  = (errReset ? 1'b0 : mOv) | (pushValid && !pushOk);
    if (popOk) begin mLast = mq[0][7:0]; void'(mq.pop_front()); end
    if (pushOk) mq.push_back({pf, pushData});
    if (rtsOffCmd) begin mRts = 1; mHold = 0; end
    else if (rtsOnCmd) begin mRts = 0; mHold = 0; end
    else if (!autoRtsEn) mHold = 0;
    else if (startBit && n >= 12) begin mRts = 1; mHold = 1; end
    else if (mHold && n < 12) begin mRts = 0; mHold = 0; end
  endfunction

  task automatic check(string tag, string what, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic checkAll(string tag);
    check(tag, "rxData", rxData, expData());
    check(tag, "status", statusByte, expStatus());
    check(tag, "count", {3'b0, fillCount}, 8'(mq.size()));
    check(tag, "rtsN", {7'b0, rtsN}, {7'b0, mRts});
  endtask

  task automatic setIn(bit psh, logic [7:0] d, logic [2:0] fl, bit pop,
                       bit sb, bit er, bit on, bit off);
    pushValid = psh; pushData = d;
    {pushBreak, pushFrameErr, pushParityErr} = fl;
    popReq = pop; startBit = sb; errReset = er; rtsOnCmd = on; rtsOffCmd = off;
  endtask

  task automatic cycle(string tag, bit psh, logic [7:0] d, logic [2:0] fl, bit pop,
                       bit sb = 0, bit er = 0, bit on = 0, bit off = 0);
    setIn(psh, d, fl, pop, sb, er, on, off);
    modelStep();
    @(posedge clk); #1;
    setIn(0, '0, '0, 0, 0, 0, 0, 0);
    checkAll(tag);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    checkAll("R10");

    // R2: character mode flags follow the oldest entry
    cycle("R2", 1, 8'h41, 3'b001, 0);
    cycle("R2", 1, 8'h42, 3'b100, 0);
    cycle("R2", 1, 8'h43, 3'b010, 0);
    cycle("R1", 0, 0, 0, 1);
    cycle("R2", 1, 8'h44, 3'b000, 1);
    cycle("R2", 0, 0, 0, 1);
    cycle("R2", 0, 0, 0, 1);
    // R6: pop on empty keeps last data
    cycle("R6", 0, 0, 0, 1);
    cycle("R6", 0, 0, 0, 1);

    // R3 / R4: block accumulation
    blockMode = 1;
    cycle("R4", 0, 0, 0, 0, 0, 1);
    cycle("R3", 1, 8'h10, 3'b001, 0);
    cycle("R3", 1, 8'h11, 3'b100, 0);
    cycle("R3", 1, 8'h12, 3'b010, 0);
    cycle("R4", 0, 0, 0, 1, 0, 1);
    cycle("R3", 0, 0, 0, 1);
    cycle("R4", 1, 8'h13, 3'b001, 1, 0, 1);
    cycle("R3", 0, 0, 0, 1);
    blockMode = 0;

    // R5: fill to full then overrun
    for (int i = 0; i < 16; i++) cycle("R1", 1, 8'(8'h80 + i), 3'(i), 0);
    cycle("R5", 1, 8'hEE, 3'b111, 0);
    cycle("R5", 1, 8'hEF, 3'b000, 1);
    cycle("R4", 0, 0, 0, 0, 0, 1);

    // R11 / R7 / R8: automatic RTS
    autoRtsEn = 1;
    cycle("R9", 0, 0, 0, 0, 0, 0, 1, 0);
    while (mq.size() > 11) cycle("R1", 0, 0, 0, 1);
    cycle("R11", 0, 0, 0, 0, 1);
    cycle("R7", 1, 8'h55, 3'b000, 0);
    cycle("R7", 0, 0, 0, 0, 1);
    cycle("R8", 0, 0, 0, 0);
    cycle("R8", 0, 0, 0, 1);
    cycle("R8", 0, 0, 0, 0);
    autoRtsEn = 0;
    cycle("R11", 1, 8'h56, 3'b000, 0, 1);
    cycle("R9", 0, 0, 0, 0, 0, 0, 1, 1);
    cycle("R9", 0, 0, 0, 0, 0, 0, 1, 0);
    autoRtsEn = 1;
    cycle("R9", 0, 0, 0, 0, 1, 0, 1, 0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if ((i % 500) == 0) begin
        blockMode = $urandom_range(0, 1);
        autoRtsEn = $urandom_range(0, 3) != 0;
      end
      cycle(blockMode ? "R3" : "R2",
            $urandom_range(0, 99) < ((i / 250) % 2 ? 70 : 40),
            8'($urandom), 3'($urandom),
            $urandom_range(0, 99) < 45,
            $urandom_range(0, 99) < 20,
            $urandom_range(0, 99) < 5,
            $urandom_range(0, 99) < 2,
            $urandom_range(0, 99) < 2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule